// File: doc/BRIEF.md
# Parallel Port Channel with Handshake Lines

This block is one register-mapped parallel I/O channel: a data port whose bits each have their own direction, plus two control lines. The first control line is an input only. It is watched for an edge of programmable polarity, and that edge can raise an interrupt. The second control line is either a second edge-sensitive input or an output. As an output it has three modes: an automatic handshake, a one-cycle strobe, or a level set by software.

A processor reaches the channel through a two-address bus with separate read and write enables. The control register sits at address 1. Address 0 is shared: a bit of the control register decides whether it reaches the direction register or the port data register. The parameter `HS_ON_WRITE` selects the side. With 0, the channel is a receiving side and its handshake is triggered by port reads. With 1, it is a transmitting side and its handshake is triggered by port writes. No other behaviour differs between the two sides.

Top module: `hsport_chan`

## Requirements
- R1: While reset is asserted, and immediately after it, every port bit is an input (`pinOe` = 0), the control register reads 0x00, `c2Oe` is 0 and `irqOut` is 0.
- R2: Address 1 reads the control register and writes its bits 5..0. Address 0 reaches the direction register when control bit 2 is 0, and the port data register when control bit 2 is 1, for both reads and writes.
- R3: `pinOe` equals the direction register, and `pinOut` drives the output latch on the bits whose direction bit is 1. A port data read returns `pinIn` on input bits and the latch on output bits.
- R4: Control bit 1 sets the active edge of `c1In` (1 = rising, 0 = falling). An active edge sets control bit 7 at the next clock edge. With control bit 5 = 0, control bit 4 sets the active edge of `c2In` (1 = rising), and that edge sets bit 6 at the next clock edge. Bits 7 and 6 ignore writes.
- R5: A port data read (address 0 with control bit 2 = 1, `rdEn` = 1) clears bits 7 and 6. If a new active edge arrives in the same cycle, its flag stays set.
- R6: `irqOut` is (bit 7 AND bit 0) OR (bit 6 AND bit 3 AND NOT bit 5).
- R7: Control bit 5 = 1 sets `c2Oe`. The output mode is set by bits 4..3: 00 is handshake, 01 is pulse, 1x is manual. In manual mode `c2Out` equals bit 3.
- R8: In handshake mode, an active `c1In` edge drives `c2Out` high from the next cycle, and a triggering access drives it low from the next cycle. If both happen in the same cycle, the access wins. The handshake level is high after reset.
- R9: In pulse mode, `c2Out` is low for exactly the one cycle that follows a triggering access, and high otherwise.
- R10: The triggering access is a port data read when `HS_ON_WRITE` = 0 and a port data write when `HS_ON_WRITE` = 1. The other access type has no effect on `c2Out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 1 | Register address (0 port/direction, 1 control) |
| rdEn | input | 1 | Read strobe; side effects taken at the clock edge |
| wrEn | input | 1 | Write strobe |
| wrData | input | WIDTH | Write data |
| rdData | output | WIDTH | Combinational read data for `addr` |
| pinIn | input | WIDTH | Sampled port pins |
| pinOut | output | WIDTH | Port output latch |
| pinOe | output | WIDTH | Per-bit output enable |
| c1In | input | 1 | First control line (edge input) |
| c2In | input | 1 | Second control line when used as input |
| c2Out | output | 1 | Second control line output value |
| c2Oe | output | 1 | Second control line output enable |
| irqOut | output | 1 | Interrupt request, active high |

## Verification
A wrong flag, handshake level or pulse register shows on `c2Out`, `irqOut` or the control-register read one cycle after the edge or access that should have changed it. The bench therefore compares every output against a behavioural model on every clock. A latch or direction error shows at once on `pinOut` and `pinOe` and in the address 0 read-back. Two instances, one per side, get identical stimulus, so a handshake triggered by the wrong access type shows up as a `c2Out` mismatch on one side only. Directed sequences cover the cases where an edge and a read or write arrive in the same cycle.

// File: rtl/hsport_pkg.sv
package hsport_pkg;
  // control register geometry
  localparam int CFG_W = 6;            // writable bits
  localparam int CR_W  = CFG_W + 2;    // plus two read-only flags
  localparam int CR_C1_IE   = 0;
  localparam int CR_C1_POL  = 1;
  localparam int CR_SHOWDAT = 2;
  localparam int CR_C2_LO   = 3;
  localparam int CR_C2_HI   = 4;
  localparam int CR_C2_DIR  = 5;

  typedef enum logic [1:0] {
    C2_INPUT     = 2'd0,
    C2_HANDSHAKE = 2'd1,
    C2_PULSE     = 2'd2,
    C2_MANUAL    = 2'd3
  } c2ModeT;

  // control -> datapath strobes
  typedef struct packed {
    logic ddrWr;
    logic outWr;
    logic showData;
  } dpStrobeT;
endpackage

// File: rtl/hsport_ctrl.sv
module hsport_ctrl
  import hsport_pkg::*;
#(
  parameter bit HS_ON_WRITE = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             addr,
  input  logic             rdEn,
  input  logic             wrEn,
  input  logic [CFG_W-1:0] wrCfg,
  input  logic             c1In,
  input  logic             c2In,
  output dpStrobeT         strobe,
  output logic [CR_W-1:0]  ctrlView,
  output logic             c2Out,
  output logic             c2Oe,
  output logic             irqOut
);
  logic [CFG_W-1:0] cfg;
  logic flag1, flag2;
  logic c1Prev, c2Prev;
  logic hsLevel, pulseLow;
  logic portSel, portRd, portWr, cfgWr;
  logic edge1, edge2, trigger;
  c2ModeT c2Mode;

  // bus decode
  assign portSel = !addr && cfg[CR_SHOWDAT];
  assign portRd  = rdEn && portSel;
  assign portWr  = wrEn && portSel;
  assign cfgWr   = wrEn && addr;

  // edge detection against the value seen at the previous clock
  assign edge1 = (c1In != c1Prev) && (c1In == cfg[CR_C1_POL]);
  assign edge2 = !cfg[CR_C2_DIR] && (c2In != c2Prev) && (c2In == cfg[CR_C2_HI]);

  // side selection: which access fires the handshake
  generate
    if (HS_ON_WRITE) begin : gTalker
      assign trigger = portWr;
    end else begin : gListener
      assign trigger = portRd;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg      <= '0;
      flag1    <= 1'b0;
      flag2    <= 1'b0;
      c1Prev   <= 1'b0;
      c2Prev   <= 1'b0;
      hsLevel  <= 1'b1;
      pulseLow <= 1'b0;
    end else begin
      c1Prev   <= c1In;
      c2Prev   <= c2In;
      if (cfgWr) cfg <= wrCfg;
      flag1    <= edge1 || (flag1 && !portRd);
      flag2    <= edge2 || (flag2 && !portRd);
      pulseLow <= trigger;
      if (trigger)    hsLevel <= 1'b0;
      else if (edge1) hsLevel <= 1'b1;
    end
  end

  always_comb begin
    if (!cfg[CR_C2_DIR])     c2Mode = C2_INPUT;
    else if (cfg[CR_C2_HI])  c2Mode = C2_MANUAL;
    else if (cfg[CR_C2_LO])  c2Mode = C2_PULSE;
    else                     c2Mode = C2_HANDSHAKE;
  end

  always_comb begin
    unique case (c2Mode)
      C2_HANDSHAKE: c2Out = hsLevel;
      C2_PULSE:     c2Out = !pulseLow;
      C2_MANUAL:    c2Out = cfg[CR_C2_LO];
      default:      c2Out = 1'b0;
    endcase
  end

  assign c2Oe   = (c2Mode != C2_INPUT);
  assign irqOut = (flag1 && cfg[CR_C1_IE]) ||
                  (flag2 && cfg[CR_C2_LO] && (c2Mode == C2_INPUT));

  assign ctrlView        = {flag1, flag2, cfg};
  assign strobe.ddrWr    = wrEn && !addr && !cfg[CR_SHOWDAT];
  assign strobe.outWr    = portWr;
  assign strobe.showData = cfg[CR_SHOWDAT];
endmodule

// File: rtl/hsport_dp.sv
module hsport_dp
  import hsport_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobeT         strobe,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  output logic [WIDTH-1:0] dpView
);
  logic [WIDTH-1:0] dirReg;
  logic [WIDTH-1:0] outLatch;
  logic [WIDTH-1:0] portSample;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg   <= '0;
      outLatch <= '0;
    end else begin
      if (strobe.ddrWr) dirReg   <= wrData;
      if (strobe.outWr) outLatch <= wrData;
    end
  end

  // per-bit read-back: pin for inputs, latch for outputs
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : gBit
      assign portSample[b] = dirReg[b] ? outLatch[b] : pinIn[b];
    end
  endgenerate

  assign pinOut = outLatch;
  assign pinOe  = dirReg;
  assign dpView = strobe.showData ? portSample : dirReg;
endmodule

// File: rtl/hsport_chan.sv
module hsport_chan
  import hsport_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter bit HS_ON_WRITE = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             addr,
  input  logic             rdEn,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  input  logic             c1In,
  input  logic             c2In,
  output logic             c2Out,
  output logic             c2Oe,
  output logic             irqOut
);
  dpStrobeT         strobe;
  logic [CR_W-1:0]  ctrlView;
  logic [WIDTH-1:0] dpView;

  hsport_ctrl #(.HS_ON_WRITE(HS_ON_WRITE)) uCtrl (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .wrCfg(wrData[CFG_W-1:0]), .c1In(c1In), .c2In(c2In),
    .strobe(strobe), .ctrlView(ctrlView),
    .c2Out(c2Out), .c2Oe(c2Oe), .irqOut(irqOut)
  );

  hsport_dp #(.WIDTH(WIDTH)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .dpView(dpView)
  );

  assign rdData = addr ? WIDTH'(ctrlView) : dpView;
endmodule

// File: rtl/hsport_chk.sv
module hsport_chk
  import hsport_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter bit HS_ON_WRITE = 1'b0
) (
  input logic             clk,
  input logic             rstN,
  input logic             addr,
  input logic             rdEn,
  input logic             wrEn,
  input logic             c1In,
  input logic             c2In,
  input logic             c2Out,
  input logic             c2Oe,
  input logic             irqOut,
  input logic [WIDTH-1:0] pinOe,
  input logic [CR_W-1:0]  ctrlView
);
  logic armed;
  logic portAcc, trig;
  logic pulseMode, hsMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  assign portAcc   = !addr && ctrlView[CR_SHOWDAT];
  assign trig      = HS_ON_WRITE ? (wrEn && portAcc) : (rdEn && portAcc);
  assign pulseMode = (ctrlView[5:3] == 3'b101);
  assign hsMode    = (ctrlView[5:3] == 3'b100);

  // R1: quiet outputs while in reset
  always_comb begin
    if (rstN == 1'b0)
      a_r1_reset_quiet: assert (pinOe == '0 && !c2Oe && !irqOut);
  end

  a_r4_c1_rise: assert property (@(posedge clk) disable iff (!rstN)
    armed && $rose(c1In) && ctrlView[CR_C1_POL] |=> ctrlView[7]);

  a_r4_c1_fall: assert property (@(posedge clk) disable iff (!rstN)
    armed && $fell(c1In) && !ctrlView[CR_C1_POL] |=> ctrlView[7]);

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    armed && rdEn && portAcc && $stable(c1In) && $stable(c2In)
    |=> !ctrlView[7] && !ctrlView[6]);

  a_r6_irq_has_source: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (ctrlView[7] && ctrlView[0]) ||
               (ctrlView[6] && ctrlView[3] && !ctrlView[5]));

  a_r7_manual_level: assert property (@(posedge clk) disable iff (!rstN)
    c2Oe && ctrlView[4] |-> c2Out == ctrlView[3]);

  a_r8_access_drops: assert property (@(posedge clk) disable iff (!rstN)
    hsMode && trig |=> !c2Out || !hsMode);

  a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    pulseMode && !c2Out && !trig |=> c2Out || !pulseMode);
endmodule

bind hsport_chan hsport_chk #(.WIDTH(WIDTH), .HS_ON_WRITE(HS_ON_WRITE)) uChk (
  .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
  .c1In(c1In), .c2In(c2In), .c2Out(c2Out), .c2Oe(c2Oe), .irqOut(irqOut),
  .pinOe(pinOe), .ctrlView(ctrlView)
);

// File: tb/hsport_chan_test.sv
module hsport_chan_test;
  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic addr = 1'b0, rdEn = 1'b0, wrEn = 1'b0;
  logic [7:0] wrData = 8'h00, pinIn = 8'h00;
  logic c1In = 1'b0, c2In = 1'b0;

  logic [7:0] rdQ [2];
  logic [7:0] outQ [2];
  logic [7:0] oeQ [2];
  logic c2OutQ [2], c2OeQ [2], irqQ [2];

  int tests = 0, fails = 0;

  // behavioural reference state, index 0 = read side, 1 = write side
  logic [7:0] mDdr [2], mLat [2];
  logic [5:0] mCfg [2];
  bit mF1 [2], mF2 [2], mP1 [2], mP2 [2], mHs [2], mPl [2];

  always #10 clk = ~clk;  // 50 MHz

  hsport_chan #(.WIDTH(8), .HS_ON_WRITE(1'b0)) uut (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdQ[0]), .pinIn(pinIn), .pinOut(outQ[0]),
    .pinOe(oeQ[0]), .c1In(c1In), .c2In(c2In), .c2Out(c2OutQ[0]),
    .c2Oe(c2OeQ[0]), .irqOut(irqQ[0]));

  hsport_chan #(.WIDTH(8), .HS_ON_WRITE(1'b1)) uutB (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdQ[1]), .pinIn(pinIn), .pinOut(outQ[1]),
    .pinOe(oeQ[1]), .c1In(c1In), .c2In(c2In), .c2Out(c2OutQ[1]),
    .c2Oe(c2OeQ[1]), .irqOut(irqQ[1]));

  task automatic chkv(string tag, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    for (int s = 0; s < 2; s++) begin
      mDdr[s] = 8'h00; mLat[s] = 8'h00; mCfg[s] = 6'h00;
      mF1[s] = 0; mF2[s] = 0; mP1[s] = 0; mP2[s] = 0;
      mHs[s] = 1; mPl[s] = 0;
    end
  endtask

  // compare all outputs with the model, then advance the model over the edge
  task automatic step();
    #2;
    for (int s = 0; s < 2; s++) begin
      logic [7:0] expRd;
      bit expIrq, expC2, sd, pRd, pWr, trg, e1, e2;
      sd = mCfg[s][2];
      if (addr) expRd = {mF1[s], mF2[s], mCfg[s]};
      else if (sd) expRd = (pinIn & ~mDdr[s]) | (mLat[s] & mDdr[s]);
      else expRd = mDdr[s];
      expIrq = (mF1[s] && mCfg[s][0]) || (mF2[s] && mCfg[s][3] && !mCfg[s][5]);
      if (mCfg[s][4]) expC2 = mCfg[s][3];
      else if (mCfg[s][3]) expC2 = !mPl[s];
      else expC2 = mHs[s];
      chkv($sformatf("R3 pinOe side%0d", s), oeQ[s], mDdr[s]);
      chkv($sformatf("R3 pinOut side%0d", s), outQ[s] & oeQ[s], mLat[s] & mDdr[s]);
      chkv($sformatf("R2 rdData side%0d", s), rdQ[s], expRd);
      chkv($sformatf("R6 irqOut side%0d", s), irqQ[s], expIrq);
      chkv($sformatf("R7 c2Oe side%0d", s), c2OeQ[s], mCfg[s][5]);
      if (mCfg[s][5])
        chkv($sformatf("R8 c2Out side%0d", s), c2OutQ[s], expC2);
      if (!rstN) continue;
      pRd = rdEn && !addr && sd;
      pWr = wrEn && !addr && sd;
      trg = (s == 1) ? pWr : pRd;
      e1 = (c1In != mP1[s]) && (c1In == mCfg[s][1]);
      e2 = !mCfg[s][5] && (c2In != mP2[s]) && (c2In == mCfg[s][4]);
      if (wrEn && !addr && !sd) mDdr[s] = wrData;
      if (pWr) mLat[s] = wrData;
      if (wrEn && addr) mCfg[s] = wrData[5:0];
      mF1[s] = e1 || (mF1[s] && !pRd);
      mF2[s] = e2 || (mF2[s] && !pRd);
      if (trg) mHs[s] = 0; else if (e1) mHs[s] = 1;
      mPl[s] = trg;
      mP1[s] = c1In;
      mP2[s] = c2In;
    end
    if (!rstN) modelReset();
    @(negedge clk);
  endtask

  task automatic busWr(logic a, logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1; step(); wrEn = 1'b0;
  endtask

  task automatic busRd(logic a);
    addr = a; rdEn = 1'b1; step(); rdEn = 1'b0;
  endtask

  task automatic peek(logic a, int exp, string tag);
    addr = a; #1;
    chkv({tag, " side0"}, rdQ[0], exp);
    chkv({tag, " side1"}, rdQ[1], exp);
  endtask

  task automatic chkC2(int expA, int expB, string tag);
    #1;
    chkv({tag, " c2Out side0"}, c2OutQ[0], expA);
    chkv({tag, " c2Out side1"}, c2OutQ[1], expB);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed;
    modelReset();
    #1 rstN = 1'b0;
    @(negedge clk);
    repeat (3) step();
    // R1: quiet during reset
    chkv("R1 pinOe in reset", oeQ[0] | oeQ[1], 0);
    chkv("R1 irq in reset", irqQ[0] | irqQ[1], 0);
    chkv("R1 c2Oe in reset", c2OeQ[0] | c2OeQ[1], 0);
    rstN = 1'b1;
    step();
    peek(1'b1, 8'h00, "R1 ctrl after reset");
    peek(1'b0, 8'h00, "R1 ddr after reset");

    // R2 / R3: shared address and read-back
    busWr(1'b0, 8'hF0);
    busWr(1'b1, 8'h04);
    busWr(1'b0, 8'hA5);
    pinIn = 8'h3C;
    peek(1'b0, 8'hAC, "R3 mixed read-back");
    chkv("R3 pinOe value", oeQ[0], 8'hF0);
    busWr(1'b1, 8'h00);
    peek(1'b0, 8'hF0, "R2 ddr view");
    busWr(1'b0, 8'h55);
    chkv("R2 ddr written via addr0", oeQ[1], 8'h55);
    busWr(1'b1, 8'h04);
    peek(1'b0, (8'h3C & 8'hAA) | (8'hA5 & 8'h55), "R2 data view");

    // R4 / R6: first line edge flag and interrupt
    busWr(1'b1, 8'h07);
    c1In = 1'b1; step();
    peek(1'b1, 8'h87, "R4 c1 rising flag");
    chkv("R6 irq on flag", irqQ[0], 1);
    busWr(1'b1, 8'hC6);
    peek(1'b1, 8'h86, "R4 flags ignore write");
    chkv("R6 irq masked", irqQ[1], 0);
    busWr(1'b1, 8'h07);

    // R5: port read clears; same-cycle edge survives
    busRd(1'b0);
    peek(1'b1, 8'h07, "R5 read clears");
    chkv("R5 irq cleared", irqQ[0], 0);
    c1In = 1'b0; step();
    peek(1'b1, 8'h07, "R4 inactive edge ignored");
    c1In = 1'b1; busRd(1'b0);
    peek(1'b1, 8'h87, "R5 edge beats clear");
    busRd(1'b0);
    peek(1'b1, 8'h07, "R5 second clear");

    // R4 / R6: second line as input, falling active
    busWr(1'b1, 8'h0C);
    c2In = 1'b1; step();
    peek(1'b1, 8'h0C, "R4 c2 inactive edge");
    c2In = 1'b0; step();
    peek(1'b1, 8'h4C, "R4 c2 falling flag");
    chkv("R6 irq from c2", irqQ[0], 1);
    busRd(1'b0);
    peek(1'b1, 8'h0C, "R5 c2 flag cleared");

    // R7: manual level
    busWr(1'b1, 8'h3C);
    chkv("R7 c2Oe set", c2OeQ[0], 1);
    chkC2(1, 1, "R7 manual high");
    busWr(1'b1, 8'h34);
    chkC2(0, 0, "R7 manual low");

    // R8 / R10: handshake
    busWr(1'b1, 8'h26);
    c1In = 1'b0; step();
    c1In = 1'b1; step();
    chkC2(1, 1, "R8 edge raises");
    busRd(1'b0);
    chkC2(0, 1, "R10 read triggers side0 only");
    busWr(1'b0, 8'h11);
    chkC2(0, 0, "R10 write triggers side1 only");
    c1In = 1'b0; step();
    c1In = 1'b1; busWr(1'b0, 8'h12);
    chkC2(1, 0, "R8 access beats edge");

    // R9: pulse mode
    busWr(1'b1, 8'h2E);
    chkC2(1, 1, "R9 idle high");
    busRd(1'b0);
    chkC2(0, 1, "R9 read pulse");
    step();
    chkC2(1, 1, "R9 pulse one cycle");
    busWr(1'b0, 8'h22);
    chkC2(1, 0, "R9 write pulse");
    step();
    chkC2(1, 1, "R9 write pulse one cycle");

    // pseudo-random traffic checked against the model every clock
    seed = 32'h1D2C3B4A;
    for (int i = 0; i < 600; i++) begin
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >>> 17);
      seed = seed ^ (seed << 5);
      addr   = seed[0];
      rdEn   = seed[1] & seed[2];
      wrEn   = seed[3] & seed[4] & (seed[5] | !seed[0]);
      wrData = seed[15:8];
      pinIn  = seed[23:16];
      c1In   = seed[24] ^ seed[25];
      c2In   = seed[26];
      step();
    end
    rdEn = 1'b0; wrEn = 1'b0;
    step();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule